// File: doc/BRIEF.md
# Debug Port Scan Access Decoder

This block sits behind a 35-bit scan data register on the target side of a debug link. A host shifts in a 3-bit request header and a 32-bit payload. When the TAP controller signals update, the block decodes the request. The instruction-select input `ir_ap_i` decides where it goes. With `ir_ap_i` low it is a read or write of the local debug-port registers. With `ir_ap_i` high it is a single access on an access-port request channel. The TAP state machine and instruction register sit outside this block. They supply capture, shift and update strobes and the access-port select.

Reads are posted. A read only loads an internal read buffer, and that value is shifted out during the next scan, together with a 3-bit acknowledge. A debug-port read at address 0xC returns the buffer without starting anything new. This lets the host collect the last value of a sequence. The block also holds:
- a bank/port selection register that extends the 2-bit header address for access-port registers;
- a control/status register with overrun detection, two sticky error flags and power-up request/acknowledge handshakes.

Top module: `dp_scan_access`

## Requirements
- R1: While `capture_i` is high, the 35-bit register loads {read buffer[31:0], ack[2:0]}. While `shift_i` is high it shifts right, with `tdi_i` entering bit 34 and `tdo_o` showing bit 0. At update, bit 0 is read-not-write (1 = read), bits [2:1] are the register address bits [3:2], and bits [34:3] are the write data.
- R2: The captured acknowledge is 3'b010 (OK) or 3'b001 (WAIT), never anything else.
- R3: A debug-port read at address 0x0 loads `ID_VALUE` into the read buffer. At 0x4 it loads the control/status view, and at 0x8 the selection view. The value appears in the data field of the next capture.
- R4: A debug-port read at address 0xC leaves the read buffer unchanged and starts no access-port request.
- R5: A debug-port write at 0x8 stores the write data ANDed with 0xFF0000F0. Access-port requests drive `ap_port_o` = selection[31:24] and `ap_addr_o` = {selection[7:4], header address[3:2], 2'b00}.
- R6: An access-port request raises `ap_req_o` and holds it, together with `ap_write_o` (1 = write), the address and the write data, until `ap_ack_i`. A read that completes without error loads `ap_rdata_i` into the read buffer.
- R7: If overrun detection is off and an access-port request is still outstanding at capture, the acknowledge is WAIT. The request shifted in during that scan is then discarded.
- R8: Overrun detection is enabled by control/status bit 0. When it is on, the acknowledge is OK while a request is outstanding. An access-port request that arrives during that time is discarded and sets sticky overrun (control/status bit 1).
- R9: An access-port completion with `ap_err_i` high sets sticky error (control/status bit 5) and does not change the read buffer.
- R10: While either sticky flag is set, access-port requests are acknowledged but never issued. Writing control/status with a 1 in a sticky flag's bit position clears that flag.
- R11: Control/status bit 28 drives `dbg_pwrup_req_o` and bit 30 drives `sys_pwrup_req_o`. Bits 29 and 31 read back `dbg_pwrup_ack_i` and `sys_pwrup_ack_i`.
- R12: After reset, every register is zero, no request is outstanding, and the first capture returns data 0 with ack OK.
- R13: Debug-port writes to addresses 0x0 and 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (test clock domain) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ir_ap_i | input | 1 | 1 = access-port scan selected, 0 = debug-port scan |
| capture_i | input | 1 | Capture strobe for the data register |
| shift_i | input | 1 | Shift strobe for the data register |
| update_i | input | 1 | Update strobe; the request is decoded here |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| ap_req_o | output | 1 | Access-port request, held until acknowledged |
| ap_write_o | output | 1 | 1 = write, 0 = read |
| ap_port_o | output | 8 | Selected access port |
| ap_addr_o | output | 8 | Access-port register byte address |
| ap_wdata_o | output | 32 | Write data |
| ap_ack_i | input | 1 | Completion of the outstanding request |
| ap_rdata_i | input | 32 | Read data, valid with `ap_ack_i` |
| ap_err_i | input | 1 | Error response, valid with `ap_ack_i` |
| dbg_pwrup_req_o | output | 1 | Debug power-up request |
| dbg_pwrup_ack_i | input | 1 | Debug power-up acknowledge |
| sys_pwrup_req_o | output | 1 | System power-up request |
| sys_pwrup_ack_i | input | 1 | System power-up acknowledge |

## Verification
A table of scans first covers the access-free paths. Identification, control/status and selection reads are interleaved with buffer reads and selection writes. Because each scan returns the previous result, one wrong read-buffer load shows up in the scan that follows it. Directed sequences then slow the responder so a second scan lands on an outstanding request. This is done once with overrun detection off, to tell WAIT-and-drop from accepting the request, and once with it on, to tell a discarded request that sets sticky overrun from a silent drop. An error response, writes to the ignored addresses and the power handshake each get their own sequence. A request counter on the channel shows when a request was wrongly issued or wrongly dropped.

// File: rtl/dp_scan_pkg.sv
package dp_scan_pkg;
  localparam int DP_DATA_W = 32;
  localparam int DP_HDR_W  = 3;
  localparam int DP_PORT_W = 8;
  localparam int DP_BANK_W = 4;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  // debug-port register index = address bits [3:2]
  localparam logic [1:0] DP_ID    = 2'd0;
  localparam logic [1:0] DP_CTRL  = 2'd1;
  localparam logic [1:0] DP_SEL   = 2'd2;
  localparam logic [1:0] DP_RDBUF = 2'd3;

  // control/status bit positions
  localparam int CS_ORUN_EN = 0;
  localparam int CS_S_ORUN  = 1;
  localparam int CS_S_ERR   = 5;
  localparam int CS_DBG_REQ = 28;
  localparam int CS_DBG_ACK = 29;
  localparam int CS_SYS_REQ = 30;
  localparam int CS_SYS_ACK = 31;

  // selection fields
  localparam int SEL_BANK_LSB = 4;
  localparam int SEL_PORT_LSB = 24;

  typedef struct packed {
    logic       orun_en;
    logic       clr_orun;
    logic       clr_err;
    logic       dbg_req;
    logic       sys_req;
  } ctrl_wr_t;
endpackage

// File: rtl/dp_scan_shreg.sv
module dp_scan_shreg #(
  parameter int W = 35
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         tdi_i,
  input  logic [W-1:0] cap_i,
  output logic [W-1:0] q_o,
  output logic         tdo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (capture_i) q_o <= cap_i;
    else if (shift_i)   q_o <= {tdi_i, q_o[W-1:1]};
  end

  assign tdo_o = q_o[0];

  AST_SHIFT_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !capture_i |=> q_o[W-2:0] == $past(q_o[W-1:1])); // R1
endmodule

// File: rtl/dp_scan_ctrl.sv
module dp_scan_ctrl
  import dp_scan_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  ctrl_wr_t             wr_fields_i,
  input  logic                 sel_wr_i,
  input  logic [DP_PORT_W-1:0] sel_port_i,
  input  logic [DP_BANK_W-1:0] sel_bank_i,
  input  logic                 set_err_i,
  input  logic                 set_orun_i,
  input  logic                 dbg_ack_i,
  input  logic                 sys_ack_i,
  output logic [DP_DATA_W-1:0] ctrl_view_o,
  output logic [DP_DATA_W-1:0] sel_view_o,
  output logic [DP_PORT_W-1:0] sel_port_o,
  output logic [DP_BANK_W-1:0] sel_bank_o,
  output logic                 orun_en_o,
  output logic                 sticky_o,
  output logic                 dbg_req_o,
  output logic                 sys_req_o
);
  logic s_orun_q, s_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      orun_en_o <= 1'b0;
      dbg_req_o <= 1'b0;
      sys_req_o <= 1'b0;
    end else if (wr_i) begin
      orun_en_o <= wr_fields_i.orun_en;
      dbg_req_o <= wr_fields_i.dbg_req;
      sys_req_o <= wr_fields_i.sys_req;
    end
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_orun_q <= 1'b0;
      s_err_q  <= 1'b0;
    end else begin
      if (set_orun_i)                         s_orun_q <= 1'b1;
      else if (wr_i && wr_fields_i.clr_orun)  s_orun_q <= 1'b0;
      if (set_err_i)                          s_err_q  <= 1'b1;
      else if (wr_i && wr_fields_i.clr_err)   s_err_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_port_o <= '0;
      sel_bank_o <= '0;
    end else if (sel_wr_i) begin
      sel_port_o <= sel_port_i;
      sel_bank_o <= sel_bank_i;
    end
  end

  assign sticky_o = s_orun_q | s_err_q;

  always_comb begin
    ctrl_view_o             = '0;
    ctrl_view_o[CS_ORUN_EN] = orun_en_o;
    ctrl_view_o[CS_S_ORUN]  = s_orun_q;
    ctrl_view_o[CS_S_ERR]   = s_err_q;
    ctrl_view_o[CS_DBG_REQ] = dbg_req_o;
    ctrl_view_o[CS_DBG_ACK] = dbg_ack_i;
    ctrl_view_o[CS_SYS_REQ] = sys_req_o;
    ctrl_view_o[CS_SYS_ACK] = sys_ack_i;
  end

  always_comb begin
    sel_view_o = '0;
    sel_view_o[SEL_PORT_LSB +: DP_PORT_W] = sel_port_o;
    sel_view_o[SEL_BANK_LSB +: DP_BANK_W] = sel_bank_o;
  end

  AST_STICKY_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_err_q && !(wr_i && wr_fields_i.clr_err) |=> s_err_q); // R9
  AST_STICKY_ORUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_orun_q && !(wr_i && wr_fields_i.clr_orun) |=> s_orun_q); // R10
  AST_PWR_REQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> dbg_req_o == $past(wr_fields_i.dbg_req) && sys_req_o == $past(wr_fields_i.sys_req)); // R11
endmodule

// File: rtl/dp_scan_ap_port.sv
module dp_scan_ap_port #(
  parameter int DATA_W = 32,
  parameter int PORT_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ap_req_o,
  output logic              ap_write_o,
  output logic [PORT_W-1:0] ap_port_o,
  output logic [ADDR_W-1:0] ap_addr_o,
  output logic [DATA_W-1:0] ap_wdata_o,
  input  logic              ap_ack_i,
  input  logic [DATA_W-1:0] ap_rdata_i,
  input  logic              ap_err_i,
  output logic              busy_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic done;

  assign done = ap_req_o & ap_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_req_o   <= 1'b0;
      ap_write_o <= 1'b0;
      ap_port_o  <= '0;
      ap_addr_o  <= '0;
      ap_wdata_o <= '0;
    end else if (start_i) begin
      ap_req_o   <= 1'b1;
      ap_write_o <= write_i;
      ap_port_o  <= port_i;
      ap_addr_o  <= addr_i;
      ap_wdata_o <= wdata_i;
    end else if (done) begin
      ap_req_o   <= 1'b0;
    end
  end

  assign busy_o    = ap_req_o;
  assign rd_done_o = done & ~ap_write_o & ~ap_err_i;
  assign err_o     = done & ap_err_i;
  assign rdata_o   = ap_rdata_i;

  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !ap_req_o); // R8
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_req_o && !ap_ack_i |=> ap_req_o && $stable(ap_addr_o) && $stable(ap_wdata_o)
      && $stable(ap_write_o) && $stable(ap_port_o)); // R6
endmodule

// File: rtl/dp_scan_access.sv
module dp_scan_access
  import dp_scan_pkg::*;
#(
  parameter logic [DP_DATA_W-1:0] ID_VALUE = 32'h1DB0_0A01
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ir_ap_i,
  input  logic                    capture_i,
  input  logic                    shift_i,
  input  logic                    update_i,
  input  logic                    tdi_i,
  output logic                    tdo_o,
  output logic                    ap_req_o,
  output logic                    ap_write_o,
  output logic [DP_PORT_W-1:0]    ap_port_o,
  output logic [DP_BANK_W+3:0]    ap_addr_o,
  output logic [DP_DATA_W-1:0]    ap_wdata_o,
  input  logic                    ap_ack_i,
  input  logic [DP_DATA_W-1:0]    ap_rdata_i,
  input  logic                    ap_err_i,
  output logic                    dbg_pwrup_req_o,
  input  logic                    dbg_pwrup_ack_i,
  output logic                    sys_pwrup_req_o,
  input  logic                    sys_pwrup_ack_i
);
  localparam int DR_W   = DP_DATA_W + DP_HDR_W;
  localparam int ADDR_W = DP_BANK_W + 4;

  logic [DR_W-1:0]      dr_q, cap_data;
  logic                 req_rnw;
  logic [1:0]           req_a;
  logic [DP_DATA_W-1:0] req_data;
  logic                 wait_q, wait_now;
  logic                 busy, sticky, orun_en;
  logic                 accept, ap_hit, dp_hit, ap_start, ap_overrun;
  logic                 ctrl_wr, sel_wr;
  logic                 rd_done, ap_fail;
  logic [DP_DATA_W-1:0] rd_rdata, rdbuf_q, ctrl_view, sel_view;
  logic [DP_PORT_W-1:0] sel_port;
  logic [DP_BANK_W-1:0] sel_bank;
  logic [ADDR_W-1:0]    ap_addr_next;
  ctrl_wr_t             ctrl_fields;

  // scan register
  assign wait_now = busy & ~orun_en;
  assign cap_data = {rdbuf_q, wait_now ? ACK_WAIT : ACK_OK};

  dp_scan_shreg #(.W(DR_W)) u_shreg (
    .clk_i, .rst_ni, .capture_i, .shift_i, .tdi_i,
    .cap_i(cap_data), .q_o(dr_q), .tdo_o
  );

  assign req_rnw  = dr_q[0];
  assign req_a    = dr_q[2:1];
  assign req_data = dr_q[DR_W-1:DP_HDR_W];

  // WAIT answered at capture discards the request shifted in during that scan
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wait_q <= 1'b0;
    else if (capture_i) wait_q <= wait_now;
  end

  assign accept     = update_i & ~wait_q;
  assign ap_hit     = accept & ir_ap_i;
  assign dp_hit     = accept & ~ir_ap_i;
  assign ap_overrun = ap_hit & busy;
  assign ap_start   = ap_hit & ~busy & ~sticky;
  assign ctrl_wr    = dp_hit & ~req_rnw & (req_a == DP_CTRL);
  assign sel_wr     = dp_hit & ~req_rnw & (req_a == DP_SEL);

  always_comb begin
    ctrl_fields.orun_en  = req_data[CS_ORUN_EN];
    ctrl_fields.clr_orun = req_data[CS_S_ORUN];
    ctrl_fields.clr_err  = req_data[CS_S_ERR];
    ctrl_fields.dbg_req  = req_data[CS_DBG_REQ];
    ctrl_fields.sys_req  = req_data[CS_SYS_REQ];
  end

  dp_scan_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(ctrl_wr), .wr_fields_i(ctrl_fields),
    .sel_wr_i(sel_wr),
    .sel_port_i(req_data[SEL_PORT_LSB +: DP_PORT_W]),
    .sel_bank_i(req_data[SEL_BANK_LSB +: DP_BANK_W]),
    .set_err_i(ap_fail), .set_orun_i(ap_overrun),
    .dbg_ack_i(dbg_pwrup_ack_i), .sys_ack_i(sys_pwrup_ack_i),
    .ctrl_view_o(ctrl_view), .sel_view_o(sel_view),
    .sel_port_o(sel_port), .sel_bank_o(sel_bank),
    .orun_en_o(orun_en), .sticky_o(sticky),
    .dbg_req_o(dbg_pwrup_req_o), .sys_req_o(sys_pwrup_req_o)
  );

  assign ap_addr_next = {sel_bank, req_a, 2'b00};

  dp_scan_ap_port #(.DATA_W(DP_DATA_W), .PORT_W(DP_PORT_W), .ADDR_W(ADDR_W)) u_ap (
    .clk_i, .rst_ni,
    .start_i(ap_start), .write_i(~req_rnw), .port_i(sel_port),
    .addr_i(ap_addr_next), .wdata_i(req_data),
    .ap_req_o, .ap_write_o, .ap_port_o, .ap_addr_o, .ap_wdata_o,
    .ap_ack_i, .ap_rdata_i, .ap_err_i,
    .busy_o(busy), .rd_done_o(rd_done), .rdata_o(rd_rdata), .err_o(ap_fail)
  );

  // read buffer: access-port completion wins over a same-cycle debug-port read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdbuf_q <= '0;
    else if (rd_done) rdbuf_q <= rd_rdata;
    else if (dp_hit && req_rnw) begin
      unique case (req_a)
        DP_ID:   rdbuf_q <= ID_VALUE;
        DP_CTRL: rdbuf_q <= ctrl_view;
        DP_SEL:  rdbuf_q <= sel_view;
        default: rdbuf_q <= rdbuf_q;
      endcase
    end
  end

  AST_ACK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> dr_q[2:0] == ACK_OK || dr_q[2:0] == ACK_WAIT); // R2
  AST_WAIT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && wait_q && !ap_req_o |=> !ap_req_o); // R7
  AST_STICKY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky && !ap_req_o |=> !ap_req_o); // R10
  AST_RDBUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_done && !(dp_hit && req_rnw && req_a != DP_RDBUF) |=> $stable(rdbuf_q)); // R4
  AST_ERR_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_req_o && ap_ack_i && ap_err_i && !dp_hit |=> $stable(rdbuf_q)); // R9
endmodule

// File: tb/dp_scan_access_tb.sv
module dp_scan_access_tb_top;
  localparam logic [31:0] ID = 32'h1DB0_0A01;
  localparam logic [2:0]  OK = 3'b010;
  localparam logic [2:0]  WT = 3'b001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_ap = 1'b0, cap = 1'b0, sft = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic tdo, ap_req, ap_write, ap_ack, ap_err;
  logic [7:0]  ap_port, ap_addr;
  logic [31:0] ap_wdata, ap_rdata;
  logic dbg_req, sys_req, dbg_ack, sys_ack;

  int checks = 0, fails = 0, cyc = 0, ap_lat = 2, req_cnt = 0;
  logic err_mode = 1'b0, done = 1'b0;
  logic [7:0]  last_wr_addr, last_wr_port;
  logic [31:0] last_wr_data;

  always #2 clk = ~clk;

  dp_scan_access dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ir_ap_i(ir_ap), .capture_i(cap), .shift_i(sft),
    .update_i(upd), .tdi_i(tdi), .tdo_o(tdo),
    .ap_req_o(ap_req), .ap_write_o(ap_write), .ap_port_o(ap_port), .ap_addr_o(ap_addr),
    .ap_wdata_o(ap_wdata), .ap_ack_i(ap_ack), .ap_rdata_i(ap_rdata), .ap_err_i(ap_err),
    .dbg_pwrup_req_o(dbg_req), .dbg_pwrup_ack_i(dbg_ack),
    .sys_pwrup_req_o(sys_req), .sys_pwrup_ack_i(sys_ack)
  );

  // access-port responder and power handshake model
  int lat_cnt = 0;
  logic req_d = 1'b0;
  assign ap_rdata = {ap_port, 8'h5A, 8'h00, ap_addr};
  assign ap_err   = err_mode & ap_ack;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_ack <= 1'b0; lat_cnt <= 0; dbg_ack <= 1'b0; sys_ack <= 1'b0; req_d <= 1'b0;
    end else begin
      dbg_ack <= dbg_req;
      sys_ack <= sys_req;
      req_d   <= ap_req;
      if (ap_req && !req_d) req_cnt <= req_cnt + 1;
      if (ap_req && ap_ack && ap_write) begin
        last_wr_addr <= ap_addr; last_wr_port <= ap_port; last_wr_data <= ap_wdata;
      end
      ap_ack <= 1'b0;
      if (ap_req && !ap_ack) begin
        if (lat_cnt >= ap_lat) begin ap_ack <= 1'b1; lat_cnt <= 0; end
        else lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic scan(input logic ap, input logic [2:0] hdr, input logic [31:0] wd,
                      output logic [2:0] ack, output logic [31:0] rd);
    logic [34:0] in_v, out_v;
    in_v = {wd, hdr};
    @(negedge clk); ir_ap = ap; cap = 1'b1;
    @(negedge clk); cap = 1'b0; sft = 1'b1;
    for (int i = 0; i < 35; i++) begin
      out_v[i] = tdo; tdi = in_v[i];
      @(negedge clk);
    end
    sft = 1'b0; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
    ack = out_v[2:0]; rd = out_v[34:3];
  endtask

  task automatic wait_idle();
    while (ap_req) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic        ap;
    logic [2:0]  hdr;
    logic [31:0] wd;
    logic [2:0]  ack;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  // header = {addr[3:2], rnw}; each row checks the result of the row before it
  localparam vec_t VECS [10] = '{
    '{1'b0, 3'b001, 32'h0,         OK, 32'h0,         8'd12}, // R12 reset capture, R1
    '{1'b0, 3'b100, 32'h1234_5678, OK, ID,            8'd3},  // R3 id read
    '{1'b0, 3'b101, 32'h0,         OK, ID,            8'd3},  // R3 write leaves buffer
    '{1'b0, 3'b111, 32'h0,         OK, 32'h1200_0070, 8'd5},  // R5 masked selection
    '{1'b1, 3'b011, 32'h0,         OK, 32'h1200_0070, 8'd4},  // R4 buffer read no change
    '{1'b0, 3'b111, 32'h0,         OK, 32'h125A_0074, 8'd6},  // R6 posted AP read, R5 addr
    '{1'b0, 3'b010, 32'h5000_0000, OK, 32'h125A_0074, 8'd4},  // R4
    '{1'b0, 3'b011, 32'h0,         OK, 32'h125A_0074, 8'd1},  // R1
    '{1'b0, 3'b111, 32'h0,         OK, 32'hF000_0000, 8'd11}, // R11 acks read back
    '{1'b1, 3'b110, 32'hCAFE_F00D, OK, 32'hF000_0000, 8'd2}   // R2
  };

  initial begin
    logic [2:0]  a;
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    check("R12 ap_req after reset", {31'b0, ap_req}, 32'h0);
    check("R12 pwr req after reset", {30'b0, dbg_req, sys_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 10; k++) begin
      scan(VECS[k].ap, VECS[k].hdr, VECS[k].wd, a, d);
      check($sformatf("R%0d vec%0d ack", VECS[k].rq, k), {29'b0, a}, {29'b0, VECS[k].ack});
      check($sformatf("R%0d vec%0d data", VECS[k].rq, k), d, VECS[k].exp);
      repeat (4) @(negedge clk);
    end
    wait_idle();
    check("R6 write addr", {24'b0, last_wr_addr}, 32'h7C);
    check("R6 write port", {24'b0, last_wr_port}, 32'h12);
    check("R6 write data", last_wr_data, 32'hCAFE_F00D);
    check("R11 pwr req pins", {30'b0, dbg_req, sys_req}, 32'h3);

    // R7: overrun detect off, request outstanding -> WAIT and drop
    ap_lat = 200;
    scan(1'b1, 3'b001, 32'h0, a, d);
    scan(1'b0, 3'b011, 32'h0, a, d);
    check("R7 wait ack", {29'b0, a}, {29'b0, WT});
    wait_idle();
    scan(1'b0, 3'b111, 32'h0, a, d);
    check("R7 ack after done", {29'b0, a}, {29'b0, OK});
    check("R7 dropped read", d, 32'h125A_0070);

    // R8: overrun detect on
    scan(1'b0, 3'b010, 32'h5000_0001, a, d);
    n = req_cnt;
    scan(1'b1, 3'b001, 32'h0, a, d);
    scan(1'b1, 3'b001, 32'h0, a, d);
    check("R8 ok while busy", {29'b0, a}, {29'b0, OK});
    wait_idle();
    check("R8 one request issued", n + 1, req_cnt);
    scan(1'b0, 3'b011, 32'h0, a, d);
    scan(1'b0, 3'b111, 32'h0, a, d);
    check("R8 sticky overrun", d, 32'hF000_0003);

    // R10: sticky blocks AP, W1C clears
    ap_lat = 1;
    n = req_cnt;
    scan(1'b1, 3'b001, 32'h0, a, d);
    check("R10 sticky ack ok", {29'b0, a}, {29'b0, OK});
    repeat (10) @(negedge clk);
    check("R10 blocked request", req_cnt, n);
    scan(1'b0, 3'b010, 32'h5000_0003, a, d);
    scan(1'b0, 3'b011, 32'h0, a, d);
    scan(1'b0, 3'b111, 32'h0, a, d);
    check("R10 overrun cleared", d, 32'hF000_0001);
    scan(1'b1, 3'b001, 32'h0, a, d);
    wait_idle();
    check("R10 request after clear", req_cnt, n + 1);

    // R9: error response
    scan(1'b0, 3'b011, 32'h0, a, d);
    err_mode = 1'b1;
    scan(1'b1, 3'b001, 32'h0, a, d);
    wait_idle();
    err_mode = 1'b0;
    scan(1'b0, 3'b111, 32'h0, a, d);
    check("R9 buffer kept on error", d, 32'hF000_0001);
    scan(1'b0, 3'b011, 32'h0, a, d);
    scan(1'b0, 3'b111, 32'h0, a, d);
    check("R9 sticky error", d, 32'hF000_0021);
    scan(1'b0, 3'b010, 32'h5000_0021, a, d);
    scan(1'b0, 3'b011, 32'h0, a, d);
    scan(1'b0, 3'b111, 32'h0, a, d);
    check("R9 error cleared", d, 32'hF000_0001);

    // R13: writes to 0x0 and 0xC ignored
    scan(1'b0, 3'b110, 32'hDEAD_BEEF, a, d);
    scan(1'b0, 3'b000, 32'h0BAD_0BAD, a, d);
    scan(1'b0, 3'b001, 32'h0, a, d);
    check("R13 rdbuf write ignored", d, 32'hF000_0001);
    scan(1'b0, 3'b111, 32'h0, a, d);
    check("R13 id write ignored", d, ID);

    // R11: drop system request
    scan(1'b0, 3'b010, 32'h1000_0001, a, d);
    repeat (3) @(negedge clk);
    check("R11 dbg only", {30'b0, dbg_req, sys_req}, 32'h2);
    scan(1'b0, 3'b011, 32'h0, a, d);
    scan(1'b0, 3'b111, 32'h0, a, d);
    check("R11 ctrl view", d, 32'h3000_0001);

    finish_run();
  end
endmodule